// File: doc/BRIEF.md
# Falling-Edge Trigger Flags and Interrupt Arbiter

This block sits between eight trigger pins and a small control processor. The pins are grouped into two 4-bit ports. Each pin is first synchronised. A high-to-low transition on an armed pin then sets that pin's sticky flag bit. Software can read the flags and clear them one bit at a time or a whole port at once.

Any newly set flag raises one shared trigger request. The block weighs that request against a timer event and against the non-maskable power-on/reset request, and it presents the processor with a vector address and a take level. The processor answers with a one-cycle acknowledge. The acknowledge retires the source being serviced and blocks further trigger and timer service until software lifts the block. A request that arrives while service is blocked or disabled stays latched and is served once it is allowed.

A wake output reports that any armed pin has its flag set, so a power-down controller can restart the clock.

Top module: `trig_irq_arbiter`

## Requirements
- R1: After reset all eight flags read 0, both sources are disabled, service is unblocked, `wake` is 0, and the power-on request is presented: `irq_take`=1, `irq_pend`=1, `irq_vec`=0x002.
- R2: A falling pin level sets its flag bit, counted from the `clk` edge that first samples the low level; the bit is visible after the third rising edge. A rising level, or a pin whose enable bit (`p0_en`/`p1_en`, bit n for pin n) is 0, sets nothing.
- R3: A port-1 pin sets its flag only while its `p1_dir` bit is 0 (input); with the bit at 1 (output) its edges are ignored.
- R4: Flags are sticky, and each captured edge sets its own bit. `clr_p0`/`clr_p1` clear all four bits of a port. When `clr_bit_we` is 1, `clr_bit_sel` selects the one bit to clear: values 0..3 are `tf0` bits 0..3 and values 4..7 are `tf1` bits 0..3. A set in the same cycle as a clear wins.
- R5: On `ier_wr`, bit 2 of `ier_wdata` enables the trigger source and bit 3 enables the timer source. A request whose source is disabled stays latched and is presented as soon as its source is enabled.
- R6: The vectors are 0x002 (power-on), 0x00A (trigger) and 0x00C (timer). The priority order is power-on, then trigger, then timer. It holds also when the trigger and timer requests latch in the same cycle.
- R7: `irq_ack` while `irq_take` is 1 clears the pending request of the presented source and blocks trigger and timer service. The power-on request is never blocked.
- R8: The block is released by `rti`, by `en_int` or by `ier_wr`. `dis_int` sets the block. A request latched while blocked is presented after release.
- R9: `wake` is 1 exactly when some flag bit is set and that pin is armed (enabled, and for port 1 also set as an input).
- R10: `irq_pend` is 1 whenever any request is latched, whether or not it is blocked or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also raises the power-on request |
| p0_pin | input | 4 | Port-0 pin levels |
| p1_pin | input | 4 | Port-1 pin levels |
| p0_en | input | 4 | Per-pin edge enable, port 0 |
| p1_en | input | 4 | Per-pin edge enable, port 1 |
| p1_dir | input | 4 | Port-1 direction, 1 = output |
| ier_wr | input | 1 | Write strobe of the source enable register |
| ier_wdata | input | 4 | Enable data: bit 2 trigger, bit 3 timer |
| en_int | input | 1 | Release the service block |
| dis_int | input | 1 | Set the service block |
| rti | input | 1 | Return from interrupt; releases the block |
| timer_evt | input | 1 | One-cycle timer overflow event |
| clr_p0 | input | 1 | Clear all port-0 flags |
| clr_p1 | input | 1 | Clear all port-1 flags |
| clr_bit_we | input | 1 | Clear the single flag chosen by clr_bit_sel |
| clr_bit_sel | input | 3 | Flag index: 0..3 port 0, 4..7 port 1 |
| irq_ack | input | 1 | Processor takes the presented interrupt |
| tf0 | output | 4 | Port-0 flags |
| tf1 | output | 4 | Port-1 flags |
| irq_take | output | 1 | An interrupt is ready to be taken |
| irq_vec | output | 12 | Vector of the presented source |
| irq_pend | output | 1 | Some request is latched |
| wake | output | 1 | An armed flag is set |

## Verification
Two pairs of functions can land in the same clock edge. A trigger flag can be set on the edge where the timer event latches. The bench times a pin fall so that its flag appears on the very edge of a timer pulse. It then expects vector 0x00A first and, after acknowledge and return, 0x00C. A pin edge can also be captured on the edge where a port clear is applied. The bench pre-sets one bit, lines a second edge up with the clear, and expects the old bit gone and the new bit kept.

// File: rtl/trig_irq_arbiter.sv
module trig_irq_arbiter #(
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] VEC_POR = 12'h002,
  parameter logic [VEC_W-1:0] VEC_TRG = 12'h00A,
  parameter logic [VEC_W-1:0] VEC_TMR = 12'h00C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       p0_pin,
  input  logic [3:0]       p1_pin,
  input  logic [3:0]       p0_en,
  input  logic [3:0]       p1_en,
  input  logic [3:0]       p1_dir,
  input  logic             ier_wr,
  input  logic [3:0]       ier_wdata,
  input  logic             en_int,
  input  logic             dis_int,
  input  logic             rti,
  input  logic             timer_evt,
  input  logic             clr_p0,
  input  logic             clr_p1,
  input  logic             clr_bit_we,
  input  logic [2:0]       clr_bit_sel,
  input  logic             irq_ack,
  output logic [3:0]       tf0,
  output logic [3:0]       tf1,
  output logic             irq_take,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_pend,
  output logic             wake
);

  logic [7:0] sync_a, sync_b, prev;
  logic [7:0] flags, armed, hit, clr_mask;
  logic       por_pend, trg_pend, tmr_pend;
  logic       ier_trg, ier_tmr, blocked;
  logic       trg_ok, tmr_ok, ack_ok;
  logic       ack_por, ack_trg, ack_tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '1;
      sync_b <= '1;
      prev   <= '1;
    end else begin
      sync_a <= {p1_pin, p0_pin};
      sync_b <= sync_a;
      prev   <= sync_b;
    end
  end

  assign armed    = {p1_en & ~p1_dir, p0_en};
  assign hit      = prev & ~sync_b & armed;
  assign clr_mask = {{4{clr_p1}}, {4{clr_p0}}} | (clr_bit_we ? (8'b1 << clr_bit_sel) : 8'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | hit;
  end

  assign tf0  = flags[3:0];
  assign tf1  = flags[7:4];
  assign wake = |(flags & armed);

  assign trg_ok   = trg_pend & ier_trg;
  assign tmr_ok   = tmr_pend & ier_tmr;
  assign irq_take = por_pend | (~blocked & (trg_ok | tmr_ok));
  assign irq_vec  = por_pend ? VEC_POR : (trg_ok ? VEC_TRG : VEC_TMR);
  assign irq_pend = por_pend | trg_pend | tmr_pend;

  assign ack_ok  = irq_ack & irq_take;
  assign ack_por = ack_ok & por_pend;
  assign ack_trg = ack_ok & ~por_pend & trg_ok;
  assign ack_tmr = ack_ok & ~por_pend & ~trg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_pend <= 1'b1;
      trg_pend <= 1'b0;
      tmr_pend <= 1'b0;
      ier_trg  <= 1'b0;
      ier_tmr  <= 1'b0;
      blocked  <= 1'b0;
    end else begin
      if (ack_por) por_pend <= 1'b0;
      trg_pend <= (trg_pend & ~ack_trg) | (|hit);
      tmr_pend <= (tmr_pend & ~ack_tmr) | timer_evt;
      if (ier_wr) begin
        ier_trg <= ier_wdata[2];
        ier_tmr <= ier_wdata[3];
      end
      if (ack_ok || dis_int)            blocked <= 1'b1;
      else if (rti || en_int || ier_wr) blocked <= 1'b0;
    end
  end

  p_por_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    por_pend |-> (irq_take && irq_vec == VEC_POR));

  p_block_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !por_pend) |-> !irq_take);

  p_ack_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_take) |=> blocked);

  p_flags_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_p0 && !clr_p1 && !clr_bit_we) |=> ((flags & $past(flags)) == $past(flags)));

  p_trg_beats_tmr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_pend && trg_ok && tmr_ok && irq_take) |-> irq_vec == VEC_TRG);

  p_pend_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_pend);

endmodule

// File: tb/trig_irq_arbiter_tb.sv
module trig_irq_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] p0_pin = 4'hF, p1_pin = 4'hF, p0_en = 0, p1_en = 0, p1_dir = 0;
  logic ier_wr = 0, en_int = 0, dis_int = 0, rti = 0, timer_evt = 0;
  logic [3:0] ier_wdata = 0;
  logic clr_p0 = 0, clr_p1 = 0, clr_bit_we = 0, irq_ack = 0;
  logic [2:0] clr_bit_sel = 0;
  logic [3:0] tf0, tf1;
  logic irq_take, irq_pend, wake;
  logic [11:0] irq_vec;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .p0_pin(p0_pin), .p1_pin(p1_pin), .p0_en(p0_en),
    .p1_en(p1_en), .p1_dir(p1_dir), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .en_int(en_int), .dis_int(dis_int), .rti(rti), .timer_evt(timer_evt),
    .clr_p0(clr_p0), .clr_p1(clr_p1), .clr_bit_we(clr_bit_we), .clr_bit_sel(clr_bit_sel),
    .irq_ack(irq_ack), .tf0(tf0), .tf1(tf1), .irq_take(irq_take), .irq_vec(irq_vec),
    .irq_pend(irq_pend), .wake(wake));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fall(int port, int b);
    if (port == 0) p0_pin[b] = 1'b0; else p1_pin[b] = 1'b0;
    tick(3);
    if (port == 0) p0_pin[b] = 1'b1; else p1_pin[b] = 1'b1;
    tick(3);
  endtask

  task automatic pulse_ack;  irq_ack = 1;   tick(); irq_ack = 0;   endtask
  task automatic pulse_rti;  rti = 1;       tick(); rti = 0;       endtask
  task automatic pulse_tmr;  timer_evt = 1; tick(); timer_evt = 0; endtask
  task automatic write_ier(logic [3:0] v);
    ier_wdata = v; ier_wr = 1; tick(); ier_wr = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; tick(2); rst_n = 1; tick();
    chk("R1 tf0", tf0, 0); chk("R1 tf1", tf1, 0); chk("R1 wake", wake, 0);
    chk("R1 take", irq_take, 1); chk("R1 vec", irq_vec, 12'h002); chk("R1 pend", irq_pend, 1);
    dis_int = 1; tick(); dis_int = 0;
    chk("R7 por not blocked", irq_take, 1);
    pulse_ack;
    chk("R7 por retired", irq_pend, 0);
    pulse_rti;
  endtask

  task automatic t_edge;
    p0_en = 4'b0101;
    p0_pin[0] = 0; tick(2);
    chk("R2 not yet", tf0, 0);
    tick();
    chk("R2 set on third edge", tf0, 4'b0001);
    p0_pin[0] = 1; tick(3);
    chk("R2 rising no effect", tf0, 4'b0001);
    fall(0, 1);
    chk("R2 disabled pin", tf0, 4'b0001);
    chk("R5 disabled source held", irq_take, 0);
    chk("R10 pend while disabled", irq_pend, 1);
    chk("R9 wake", wake, 1);
    p0_en = 0; tick();
    chk("R9 wake needs enable", wake, 0);
    p0_en = 4'b0101; tick();
  endtask

  task automatic t_dir;
    p1_en = 4'hF; p1_dir = 4'b0001;
    fall(1, 0);
    chk("R3 output pin ignored", tf1, 0);
    fall(1, 2);
    chk("R3 input pin captured", tf1, 4'b0100);
  endtask

  task automatic t_clear;
    clr_bit_sel = 6; clr_bit_we = 1; tick(); clr_bit_we = 0;
    chk("R4 clear bit 6", tf1, 0);
    p0_en = 4'hF;
    fall(0, 2); fall(0, 3);
    chk("R4 each edge kept", tf0, 4'b1101);
    clr_bit_sel = 2; clr_bit_we = 1; tick(); clr_bit_we = 0;
    chk("R4 clear bit 2", tf0, 4'b1001);
    clr_p0 = 1; tick(); clr_p0 = 0;
    chk("R4 clear port", tf0, 0);
    fall(0, 0);
    p0_pin[1] = 0; tick(2); clr_p0 = 1; tick(); clr_p0 = 0; p0_pin[1] = 1; tick(3);
    chk("R4 set beats clear", tf0, 4'b0010);
    clr_p0 = 1; tick(); clr_p0 = 0;
  endtask

  task automatic t_enable;
    write_ier(4'b0100);
    chk("R5 enabled take", irq_take, 1);
    chk("R6 trigger vector", irq_vec, 12'h00A);
    pulse_ack;
    chk("R7 retired", irq_pend, 0);
    chk("R7 blocked", irq_take, 0);
    pulse_rti;
    pulse_tmr;
    chk("R5 timer disabled", irq_take, 0);
    chk("R10 timer pend", irq_pend, 1);
    write_ier(4'b1100);
    chk("R5 timer enabled", irq_vec, 12'h00C);
    chk("R5 timer take", irq_take, 1);
    pulse_ack; pulse_rti;
  endtask

  task automatic t_same_cycle;
    p0_pin[3] = 0; tick(2);
    timer_evt = 1; tick(); timer_evt = 0;
    chk("R6 both latch, take", irq_take, 1);
    chk("R6 trigger first", irq_vec, 12'h00A);
    p0_pin[3] = 1;
    pulse_ack;
    chk("R7 blocked after ack", irq_take, 0);
    chk("R10 timer waits", irq_pend, 1);
    pulse_rti;
    chk("R6 timer second", irq_vec, 12'h00C);
    chk("R8 rti release", irq_take, 1);
    pulse_ack;
    chk("R7 all retired", irq_pend, 0);
  endtask

  task automatic t_block;
    pulse_tmr;
    chk("R8 blocked holds", irq_take, 0);
    en_int = 1; tick(); en_int = 0;
    chk("R8 en_int release", irq_take, 1);
    pulse_ack;
    pulse_tmr;
    chk("R8 still blocked", irq_take, 0);
    write_ier(4'b1100);
    chk("R8 ier write release", irq_take, 1);
    pulse_ack; pulse_rti;
    dis_int = 1; tick(); dis_int = 0;
    pulse_tmr;
    chk("R8 dis_int blocks", irq_take, 0);
    pulse_rti;
    chk("R8 release after dis", irq_vec, 12'h00C);
    pulse_ack; pulse_rti;
  endtask

  initial begin
    t_reset;
    t_edge;
    t_dir;
    t_clear;
    t_enable;
    t_same_cycle;
    t_block;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule